// File: doc/BRIEF.md
# Store Unit with Misalignment Trap

This block sits between a 32-bit processor core and a simple write channel with separate address, data and response handshakes. It takes one store request at a time. The request holds a base register value, a signed immediate offset, the store data and an access size. The block adds the base and offset to form the effective address. It checks that address against the size, then sends one bus write. The write carries a word-aligned address, the data copied into every lane the access can reach, and the byte strobes that choose the lanes to update.

If the access breaks its natural alignment and checking is enabled, the block reports a trap and sends nothing to the bus. No address valid and no data valid are raised, and the strobes stay at zero. This rule matters because a write with strobes still set would change bytes of the aligned word, even though the store is being thrown away.

The request side has a valid/ready pair. A single-cycle `done` pulse marks the end of each request. It comes after the write response for a store that went to the bus, and together with a `trap` pulse for a store that was rejected.

Top module: `store_path_unit`

## Requirements
- R1: The effective address is `req_base` plus `req_offset` sign-extended to the address width. `aw_addr` is that address with bits [1:0] forced to zero.
- R2: `req_size` code 0 is a byte store. Its strobe is 4'b0001 shifted left by address bits [1:0], and `req_data[7:0]` appears in all four byte lanes of `w_data`.
- R3: `req_size` code 1 is a halfword store. Its strobe is 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1, and `req_data[15:0]` appears in both halves of `w_data`.
- R4: `req_size` codes 2 and 3 are word stores. Their strobe is 4'b1111 and `w_data` equals `req_data`.
- R5: With checking enabled, a halfword store with address bit 0 set is misaligned, and so is a word store whose address bits [1:0] are not 00. A byte store is never misaligned.
- R6: A misaligned store raises `trap` and `done` together for exactly one cycle, on the cycle after it is accepted. It never raises `aw_valid` or `w_valid`, and the memory behind the bus is left unchanged.
- R7: `aw_valid` and `w_valid` are each held high, with a stable payload, until their own ready is seen. The two channels complete independently of each other.
- R8: `b_ready` rises only after both the address and the data have been accepted. `done` pulses for one cycle after the response handshake. `req_ready` stays low while a store is in flight.
- R9: With the `CHECK_ALIGN` parameter at 0, no trap is ever raised. A misaligned store is issued as a write to the aligned word, using the strobes from R2 to R4.
- R10: While `rst_n` is low, `trap`, `done`, `aw_valid`, `w_valid` and `req_ready` stay low, even if a misaligned request is presented.
- R11: `w_strb` is 4'b0000 in every cycle where `w_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Store request present |
| req_ready | output | 1 | Block can accept a request |
| req_base | input | ADDR_W | Base register value |
| req_offset | input | IMM_W | Signed immediate offset |
| req_data | input | 32 | Store data, right-justified |
| req_size | input | 2 | Size: 0 byte, 1 halfword, 2 or 3 word |
| aw_valid | output | 1 | Write address valid |
| aw_ready | input | 1 | Write address accepted |
| aw_addr | output | ADDR_W | Word-aligned write address |
| w_valid | output | 1 | Write data valid |
| w_ready | input | 1 | Write data accepted |
| w_data | output | 32 | Lane-replicated write data |
| w_strb | output | 4 | Byte write strobes |
| b_valid | input | 1 | Write response valid |
| b_ready | output | 1 | Ready for write response |
| done | output | 1 | One-cycle request completion pulse |
| trap | output | 1 | One-cycle misaligned-store pulse |

## Verification
The bench builds two instances.

The main instance has `CHECK_ALIGN=1` and is connected to a memory model whose address and data ready latencies can be set separately. This makes reachable the trap path for every misaligned offset, the proof that a rejected store leaves the memory word and the write count unchanged, and the back-pressure orderings.

The second instance has `CHECK_ALIGN=0` and is connected to a port that is always ready. This makes reachable the case where a misaligned word store is issued to the aligned word with all four strobes set.

// File: rtl/stu_pkg.sv
package stu_pkg;
    localparam int BUS_BYTES = 4;
    localparam int BUS_W     = BUS_BYTES * 8;
    localparam int LANE_W    = $clog2(BUS_BYTES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } st_size_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_XFER = 2'd1,
        PH_RESP = 2'd2
    } st_phase_e;
endpackage

// File: rtl/stu_addr_gen.sv
module stu_addr_gen
    import stu_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int IMM_W       = 12,
    parameter bit CHECK_ALIGN = 1'b1
) (
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base,
    input  logic [IMM_W-1:0]  offset,
    input  logic [1:0]        size,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [LANE_W-1:0] lane,
    output logic              misaligned
);
    localparam int EXT_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] eff_addr;
    logic              bad_fit;

    always_comb begin
        eff_addr = base + {{EXT_W{offset[IMM_W-1]}}, offset};
        bus_addr = {eff_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
        lane     = eff_addr[LANE_W-1:0];
        case (size)
            SZ_BYTE: bad_fit = 1'b0;
            SZ_HALF: bad_fit = eff_addr[0];
            default: bad_fit = |eff_addr[LANE_W-1:0];
        endcase
    end

    generate
        if (CHECK_ALIGN) begin : g_check
            assign misaligned = rst_n & bad_fit;
        end else begin : g_nocheck
            assign misaligned = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/stu_lane_fmt.sv
module stu_lane_fmt
    import stu_pkg::*;
(
    input  logic [1:0]           size,
    input  logic [LANE_W-1:0]    lane,
    input  logic [BUS_W-1:0]     data,
    output logic [BUS_W-1:0]     wdata,
    output logic [BUS_BYTES-1:0] strb
);
    for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
        always_comb begin
            case (size)
                SZ_BYTE: begin
                    wdata[8*i +: 8] = data[7:0];
                    strb[i]         = (lane == LANE_W'(i));
                end
                SZ_HALF: begin
                    wdata[8*i +: 8] = data[8*(i%2) +: 8];
                    strb[i]         = (lane[1] == ((i / 2) % 2 == 1));
                end
                default: begin
                    wdata[8*i +: 8] = data[8*i +: 8];
                    strb[i]         = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/store_path_unit.sv
module store_path_unit
    import stu_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int IMM_W       = 12,
    parameter bit CHECK_ALIGN = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_base,
    input  logic [IMM_W-1:0]     req_offset,
    input  logic [BUS_W-1:0]     req_data,
    input  logic [1:0]           req_size,
    output logic                 aw_valid,
    input  logic                 aw_ready,
    output logic [ADDR_W-1:0]    aw_addr,
    output logic                 w_valid,
    input  logic                 w_ready,
    output logic [BUS_W-1:0]     w_data,
    output logic [BUS_BYTES-1:0] w_strb,
    input  logic                 b_valid,
    output logic                 b_ready,
    output logic                 done,
    output logic                 trap
);
    typedef struct packed {
        st_phase_e             ph;
        logic                  aw_pend;
        logic                  w_pend;
        logic [ADDR_W-1:0]     addr;
        logic [BUS_W-1:0]      data;
        logic [BUS_BYTES-1:0]  strb;
        logic                  done;
        logic                  trap;
    } regs_t;

    regs_t r_d, r_q;

    logic [ADDR_W-1:0]    fit_addr;
    logic [LANE_W-1:0]    fit_lane;
    logic                 fit_bad;
    logic [BUS_W-1:0]     fmt_data;
    logic [BUS_BYTES-1:0] fmt_strb;

    stu_addr_gen #(
        .ADDR_W      (ADDR_W),
        .IMM_W       (IMM_W),
        .CHECK_ALIGN (CHECK_ALIGN)
    ) u_addr (
        .rst_n      (rst_n),
        .base       (req_base),
        .offset     (req_offset),
        .size       (req_size),
        .bus_addr   (fit_addr),
        .lane       (fit_lane),
        .misaligned (fit_bad)
    );

    stu_lane_fmt u_fmt (
        .size  (req_size),
        .lane  (fit_lane),
        .data  (req_data),
        .wdata (fmt_data),
        .strb  (fmt_strb)
    );

    assign req_ready = rst_n && (r_q.ph == PH_IDLE);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.trap = 1'b0;
        case (r_q.ph)
            PH_IDLE: begin
                if (req_valid && req_ready) begin
                    if (fit_bad) begin
                        r_d.done = 1'b1;
                        r_d.trap = 1'b1;
                    end else begin
                        r_d.ph      = PH_XFER;
                        r_d.aw_pend = 1'b1;
                        r_d.w_pend  = 1'b1;
                        r_d.addr    = fit_addr;
                        r_d.data    = fmt_data;
                        r_d.strb    = fmt_strb;
                    end
                end
            end
            PH_XFER: begin
                if (r_q.aw_pend && aw_ready) r_d.aw_pend = 1'b0;
                if (r_q.w_pend && w_ready) begin
                    r_d.w_pend = 1'b0;
                    r_d.strb   = '0;
                end
                if (!r_d.aw_pend && !r_d.w_pend) r_d.ph = PH_RESP;
            end
            PH_RESP: begin
                if (b_valid) begin
                    r_d.done = 1'b1;
                    r_d.ph   = PH_IDLE;
                end
            end
            default: r_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{ph: PH_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign aw_valid = r_q.aw_pend;
    assign aw_addr  = r_q.addr;
    assign w_valid  = r_q.w_pend;
    assign w_data   = r_q.data;
    assign w_strb   = r_q.strb;
    assign b_ready  = (r_q.ph == PH_RESP);
    assign done     = r_q.done;
    assign trap     = r_q.trap;
endmodule

// File: rtl/stu_checker.sv
module stu_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              aw_valid,
    input logic              aw_ready,
    input logic [ADDR_W-1:0] aw_addr,
    input logic              w_valid,
    input logic              w_ready,
    input logic [31:0]       w_data,
    input logic [3:0]        w_strb,
    input logic              b_valid,
    input logic              b_ready,
    input logic              done,
    input logic              trap
);
    a_r1_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        aw_valid |-> aw_addr[1:0] == 2'b00);

    a_r7_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        aw_valid && !aw_ready |=> aw_valid && $stable(aw_addr));

    a_r7_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid && !w_ready |=> w_valid && $stable(w_data) && $stable(w_strb));

    a_r11_strb_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !w_valid |-> w_strb == 4'b0000);

    a_r6_trap_single: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> !trap);

    a_r6_trap_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> done);

    a_r6_trap_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> !aw_valid && !w_valid);

    a_r8_bready_after_both: assert property (@(posedge clk) disable iff (!rst_n)
        b_ready |-> !aw_valid && !w_valid);

    a_r8_done_source: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> trap || $past(b_valid && b_ready));
endmodule

bind store_path_unit stu_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .aw_valid (aw_valid),
    .aw_ready (aw_ready),
    .aw_addr  (aw_addr),
    .w_valid  (w_valid),
    .w_ready  (w_ready),
    .w_data   (w_data),
    .w_strb   (w_strb),
    .b_valid  (b_valid),
    .b_ready  (b_ready),
    .done     (done),
    .trap     (trap)
);

// File: tb/store_path_unit_bench.sv
`timescale 1ns/1ps
module store_path_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_base = '0;
    logic [11:0] req_offset = '0;
    logic [31:0] req_data = '0;
    logic [1:0]  req_size = '0;
    logic        aw_valid, aw_ready, w_valid, w_ready, b_ready, done, trap;
    logic        b_valid;
    logic [31:0] aw_addr, w_data;
    logic [3:0]  w_strb;

    logic        n_req_valid = 1'b0;
    logic        n_req_ready, n_aw_valid, n_w_valid, n_b_ready, n_done, n_trap;
    logic [31:0] n_aw_addr, n_w_data;
    logic [3:0]  n_w_strb;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    store_path_unit #(.CHECK_ALIGN(1'b1)) u_store_path_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_base(req_base), .req_offset(req_offset), .req_data(req_data),
        .req_size(req_size), .aw_valid(aw_valid), .aw_ready(aw_ready),
        .aw_addr(aw_addr), .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data),
        .w_strb(w_strb), .b_valid(b_valid), .b_ready(b_ready), .done(done),
        .trap(trap)
    );

    store_path_unit #(.CHECK_ALIGN(1'b0)) u_store_path_unit_nochk (
        .clk(clk), .rst_n(rst_n), .req_valid(n_req_valid), .req_ready(n_req_ready),
        .req_base(req_base), .req_offset(req_offset), .req_data(req_data),
        .req_size(req_size), .aw_valid(n_aw_valid), .aw_ready(1'b1),
        .aw_addr(n_aw_addr), .w_valid(n_w_valid), .w_ready(1'b1), .w_data(n_w_data),
        .w_strb(n_w_strb), .b_valid(1'b1), .b_ready(n_b_ready), .done(n_done),
        .trap(n_trap)
    );

    // memory model with separate ready latencies
    int          aw_lat = 0, w_lat = 0;
    int          aw_cnt = 0, w_cnt = 0;
    logic [31:0] mem [16];
    logic        got_a = 1'b0, got_w = 1'b0;
    logic [3:0]  a_idx;
    logic [31:0] wd;
    logic [3:0]  ws;
    int          wr_count = 0, aw_cycles = 0;
    logic [31:0] last_addr, last_data;
    logic [3:0]  last_strb;
    logic [31:0] n_last_addr = '0;
    logic [3:0]  n_last_strb = '0;
    int          n_trap_seen = 0, n_writes = 0;

    assign aw_ready = aw_valid && (aw_cnt >= aw_lat);
    assign w_ready  = w_valid && (w_cnt >= w_lat);

    initial b_valid = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= 32'hC3C3_0000 | i;
            got_a <= 1'b0; got_w <= 1'b0; b_valid <= 1'b0;
            aw_cnt <= 0; w_cnt <= 0;
        end else begin
            aw_cnt <= (aw_valid && !aw_ready) ? aw_cnt + 1 : 0;
            w_cnt  <= (w_valid && !w_ready) ? w_cnt + 1 : 0;
            if (aw_valid) aw_cycles <= aw_cycles + 1;
            if (aw_valid && aw_ready) begin
                got_a <= 1'b1; a_idx <= aw_addr[5:2]; last_addr <= aw_addr;
            end
            if (w_valid && w_ready) begin
                got_w <= 1'b1; wd <= w_data; ws <= w_strb;
                last_data <= w_data; last_strb <= w_strb;
                wr_count <= wr_count + 1;
            end
            if (got_a && got_w && !b_valid) begin
                for (int i = 0; i < 4; i++)
                    if (ws[i]) mem[a_idx][8*i +: 8] <= wd[8*i +: 8];
                b_valid <= 1'b1; got_a <= 1'b0; got_w <= 1'b0;
            end
            if (b_valid && b_ready) b_valid <= 1'b0;
            if (n_trap) n_trap_seen <= n_trap_seen + 1;
            if (n_w_valid) begin
                n_last_addr <= n_aw_addr; n_last_strb <= n_w_strb;
                n_writes <= n_writes + 1;
            end
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_strb(input logic [1:0] sz, input logic [1:0] a);
        case (sz)
            2'd0: return 4'b0001 << a;
            2'd1: return a[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] exp_data(input logic [1:0] sz, input logic [31:0] d);
        case (sz)
            2'd0: return {4{d[7:0]}};
            2'd1: return {2{d[15:0]}};
            default: return d;
        endcase
    endfunction

    // one store through the main instance, results checked inside
    task automatic t_store(input string tag, input logic [31:0] base,
                           input logic [11:0] off, input logic [31:0] data,
                           input logic [1:0] sz, input bit bad);
        logic [31:0] ea, old_word, new_word, s_data;
        logic [3:0]  s_strb;
        int          wr0, aw0, waited;
        bit          got_done, got_trap;
        ea = base + {{20{off[11]}}, off};
        old_word = mem[ea[5:2]];
        wr0 = wr_count; aw0 = aw_cycles;
        @(negedge clk);
        req_base = base; req_offset = off; req_data = data; req_size = sz;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        got_done = done; got_trap = trap;
        if (bad) begin
            check("R6", {tag, " trap"}, 32'(got_trap), 32'd1);
            check("R6", {tag, " done"}, 32'(got_done), 32'd1);
            check("R6", {tag, " aw_valid"}, 32'(aw_valid), 32'd0);
            @(negedge clk);
            check("R6", {tag, " trap width"}, 32'(trap), 32'd0);
            check("R6", {tag, " write count"}, 32'(wr_count - wr0), 32'd0);
            check("R6", {tag, " aw cycles"}, 32'(aw_cycles - aw0), 32'd0);
            check("R6", {tag, " memory"}, mem[ea[5:2]], old_word);
        end else begin
            check("R8", {tag, " req_ready busy"}, 32'(req_ready), 32'd0);
            check("R5", {tag, " no trap"}, 32'(got_trap), 32'd0);
            waited = 0;
            while (!done && waited < 40) begin
                @(negedge clk);
                waited++;
            end
            check("R8", {tag, " done"}, 32'(done), 32'd1);
            check("R5", {tag, " trap at done"}, 32'(trap), 32'd0);
            s_strb = exp_strb(sz, ea[1:0]);
            s_data = exp_data(sz, data);
            check("R1", {tag, " addr"}, last_addr, {ea[31:2], 2'b00});
            check(tag, {tag, " strb"}, 32'(last_strb), 32'(s_strb));
            check(tag, {tag, " data"}, last_data, s_data);
            for (int i = 0; i < 4; i++) begin
                new_word[8*i +: 8] = s_strb[i] ? s_data[8*i +: 8] : old_word[8*i +: 8];
            end
            check(tag, {tag, " memory"}, mem[ea[5:2]], new_word);
            @(negedge clk);
            check("R8", {tag, " done width"}, 32'(done), 32'd0);
        end
        check("R11", {tag, " strb idle"}, 32'(w_strb), 32'd0);
    endtask

    task automatic t_reset_quiet();
        req_base = 32'h0001_0000; req_offset = 12'h001; req_size = 2'd2;
        req_valid = 1'b1; n_req_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R10", "trap in reset", 32'(trap), 32'd0);
        check("R10", "done in reset", 32'(done), 32'd0);
        check("R10", "aw_valid in reset", 32'(aw_valid), 32'd0);
        check("R10", "w_valid in reset", 32'(w_valid), 32'd0);
        check("R10", "req_ready in reset", 32'(req_ready), 32'd0);
        req_valid = 1'b0; n_req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", "req_ready after reset", 32'(req_ready), 32'd1);
        check("R11", "strb after reset", 32'(w_strb), 32'd0);
    endtask

    task automatic t_bytes();
        for (int k = 0; k < 4; k++)
            t_store("R2", 32'h0001_0000, 12'(k), 32'h1234_5600 | k, 2'd0, 1'b0);
    endtask

    task automatic t_halves();
        t_store("R3", 32'h0001_0000, 12'h004, 32'hFFFF_BEEF, 2'd1, 1'b0);
        t_store("R3", 32'h0001_0000, 12'h006, 32'h0000_CAFE, 2'd1, 1'b0);
    endtask

    task automatic t_word_neg();
        t_store("R4", 32'h0001_0020, 12'hFF8, 32'hDEAD_BEEF, 2'd2, 1'b0);
        t_store("R4", 32'h0001_0000, 12'h00C, 32'h0BAD_F00D, 2'd3, 1'b0);
    endtask

    task automatic t_misaligned();
        t_store("R5", 32'h0001_FFE0, 12'h007, 32'h0000_AAAA, 2'd1, 1'b1);
        for (int k = 1; k < 4; k++)
            t_store("R5", 32'h0001_0010, 12'(k), 32'h5555_5555, 2'd2, 1'b1);
    endtask

    task automatic t_backpressure();
        aw_lat = 3; w_lat = 0;
        t_store("R7", 32'h0001_0030, 12'h000, 32'h7777_0001, 2'd2, 1'b0);
        aw_lat = 0; w_lat = 4;
        t_store("R7", 32'h0001_0034, 12'h002, 32'h0000_9911, 2'd1, 1'b0);
        aw_lat = 2; w_lat = 2;
        t_store("R8", 32'h0001_0038, 12'h001, 32'h0000_0042, 2'd0, 1'b0);
        aw_lat = 0; w_lat = 0;
    endtask

    task automatic t_nocheck();
        int w0, waited;
        w0 = n_writes;
        @(negedge clk);
        req_base = 32'h0001_0040; req_offset = 12'h003; req_data = 32'h0102_0304;
        req_size = 2'd2; n_req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        n_req_valid = 1'b0;
        waited = 0;
        while (!n_done && waited < 20) begin
            @(negedge clk);
            waited++;
        end
        check("R9", "done", 32'(n_done), 32'd1);
        check("R9", "trap count", 32'(n_trap_seen), 32'd0);
        check("R9", "one write", 32'(n_writes - w0), 32'd1);
        check("R9", "addr", n_last_addr, 32'h0001_0040);
        check("R9", "strb", 32'(n_last_strb), 32'hF);
    endtask

    initial begin
        t_reset_quiet();
        t_bytes();
        t_halves();
        t_word_neg();
        t_misaligned();
        t_backpressure();
        t_nocheck();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule